// File: doc/BRIEF.md
# Shared-RAM Mailbox Interrupt Controller

This block sits between a host processor and a slave board that exchange data through a two-port RAM. It raises four active-low interrupt flags. Two go to the slave: the host has written, and the host has read. Two go to the host: the slave has written, and the slave has read. No flag has a register of its own. A flag is set or cleared by a host access that lands in one of two address windows, or by a short active-low request or acknowledge pulse from the slave. The two windows are the window whose top address nibble is 0x7 and the window whose top nibble is 0xB. The block also reports the cycle in which both ports hit the same RAM cell while at least one of them writes, because the stored data is not reliable in that case.

The host bus is synchronous to `clk_i`. An access is qualified by the low chip select and a low write or read strobe. The block treats the first cycle of such an access as the event. The slave pulse lines may be asynchronous. They pass through a `SYNC_STAGES`-deep synchroniser and a falling-edge detector, so a pulse of any length acts exactly once. The RAM holds `2**MEM_AW` bytes. The host address is folded onto that depth by its low `MEM_AW` bits, while the window is decoded from its top nibble.

Top module: `dpm_mailbox`

## Requirements
- R1: While `rst_ni` is low, all four interrupt outputs are high and `collision_o` is low.
- R2: A host write (chip select low, write strobe low) whose address has top nibble 0x7 drives `irq_hw_no` low at the first clock edge of the access.
- R3: A low pulse on `hw_ack_ni` drives `irq_hw_no` high at the third rising edge after the first edge that samples the line low (SYNC_STAGES=2).
- R4: A host read (chip select low, read strobe low, write strobe high) with top address nibble 0xB drives `irq_hr_no` low at its first edge. A low pulse on `hr_ack_ni` drives it high with the latency given in R3.
- R5: A low pulse on `sw_req_ni` drives `irq_sw_no` low with the latency given in R3. The first edge of a host write with top nibble 0xB drives it high.
- R6: A low pulse on `sr_req_ni` drives `irq_sr_no` low with the latency given in R3. The first edge of a host read with top nibble 0x7 drives it high.
- R7: A strobe or pulse line that stays low for several cycles acts only once, on its leading edge. After that first edge, its continued low level neither sets nor clears any flag.
- R8: When a set event and a clear event for the same flag fall on the same edge, the flag ends up set (low).
- R9: Host accesses whose top nibble is neither 0x7 nor 0xB leave all four flags unchanged.
- R10: `collision_o` goes high for exactly the one cycle after a cycle in which both ports access the same RAM cell (host address low `MEM_AW` bits equal to `slv_addr_i`) and at least one of them writes. It stays low if both ports only read, or if the cells differ.
- R11: A byte written by either port can be read from the other port. Read data appears on `host_rdata_o` or `slv_rdata_o` right after the edge that ends the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cs_ni | input | 1 | Host chip select, active low |
| host_wr_ni | input | 1 | Host write strobe, active low |
| host_rd_ni | input | 1 | Host read strobe, active low |
| host_addr_i | input | ADDR_W | Host byte address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data, registered |
| slv_en_i | input | 1 | Slave RAM access enable |
| slv_we_i | input | 1 | Slave write enable |
| slv_addr_i | input | MEM_AW | Slave RAM address |
| slv_wdata_i | input | DATA_W | Slave write data |
| slv_rdata_o | output | DATA_W | Slave read data, registered |
| hw_ack_ni | input | 1 | Slave acknowledge of host write, low pulse |
| hr_ack_ni | input | 1 | Slave acknowledge of host read, low pulse |
| sw_req_ni | input | 1 | Slave write-done request, low pulse |
| sr_req_ni | input | 1 | Slave read-done request, low pulse |
| irq_hw_no | output | 1 | Host-wrote interrupt to slave, active low |
| irq_hr_no | output | 1 | Host-read interrupt to slave, active low |
| irq_sw_no | output | 1 | Slave-wrote interrupt to host, active low |
| irq_sr_no | output | 1 | Slave-read interrupt to host, active low |
| collision_o | output | 1 | Same-cell clash seen in the previous cycle |

## Verification
Each flag is driven through a full set-then-clear round trip. These runs show that window 0x7 and window 0xB are decoded separately, and that each slave line steers only its own flag. Further patterns test the edge behaviour. A write strobe held low while an acknowledge arrives shows that a held level does not act again. A set event placed on the same edge as an already-synchronised clear pulse shows the priority. Accesses outside both windows, including one that aliases onto a live RAM cell, show that the decode ignores the low address bits. The collision patterns pair write/read, read/write, write/write, read/read and different-cell accesses, so the clash test is shown to depend on both the address match and the write qualifier.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  // flag slots
  localparam int unsigned IDX_HW = 0;
  localparam int unsigned IDX_HR = 1;
  localparam int unsigned IDX_SW = 2;
  localparam int unsigned IDX_SR = 3;
  // top-nibble window codes
  localparam logic [3:0] WIN_DOWN = 4'h7;
  localparam logic [3:0] WIN_UP   = 4'hB;
endpackage

// File: rtl/dpm_fall_det.sv
module dpm_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_ni,
  output logic fall_o
);
  logic lvl;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_bypass
      assign lvl = line_ni;
    end else begin : g_sync
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sync_q <= '1;
        end else begin
          sync_q[0] <= line_ni;
          for (int i = 1; i < int'(STAGES); i++) sync_q[i] <= sync_q[i-1];
        end
      end
      assign lvl = sync_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl;
  end

  assign fall_o = prev_q & ~lvl;

  // R7
  one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dpm_irq_flag.sv
module dpm_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_no <= 1'b1;
    else if (set_i) flag_no <= 1'b0;   // set wins over clear
    else if (clr_i) flag_no <= 1'b1;
  end

  // R8
  set_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> !flag_no);
  // R3
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> flag_no);
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_no));
endmodule

// File: rtl/dpm_dual_ram.sv
module dpm_dual_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic          clash_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          clash_now;

  always_ff @(posedge clk_i) begin
    if (a_en_i && a_we_i) mem[a_addr_i] <= a_wdata_i;
    if (b_en_i && b_we_i) mem[b_addr_i] <= b_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_en_i && !a_we_i) a_rdata_o <= mem[a_addr_i];
      if (b_en_i && !b_we_i) b_rdata_o <= mem[b_addr_i];
    end
  end

  assign clash_now = a_en_i && b_en_i && (a_addr_i == b_addr_i) && (a_we_i || b_we_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clash_o <= 1'b0;
    else         clash_o <= clash_now;
  end

  // R10
  rd_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && b_en_i && !a_we_i && !b_we_i) |=> !clash_o);
  // R10
  diff_cell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_addr_i != b_addr_i) |=> !clash_o);
endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
  import dpm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned MEM_AW      = 10,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_cs_ni,
  input  logic              host_wr_ni,
  input  logic              host_rd_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              slv_en_i,
  input  logic              slv_we_i,
  input  logic [MEM_AW-1:0] slv_addr_i,
  input  logic [DATA_W-1:0] slv_wdata_i,
  output logic [DATA_W-1:0] slv_rdata_o,
  input  logic              hw_ack_ni,
  input  logic              hr_ack_ni,
  input  logic              sw_req_ni,
  input  logic              sr_req_ni,
  output logic              irq_hw_no,
  output logic              irq_hr_no,
  output logic              irq_sw_no,
  output logic              irq_sr_no,
  output logic              collision_o
);
  localparam int unsigned WIN_LSB = ADDR_W - 4;

  logic                 host_wr_act, host_rd_act;
  logic                 host_wr_q, host_rd_q;
  logic                 host_wr_ev, host_rd_ev;
  logic [3:0]           win;
  logic                 in_down, in_up;
  logic [NUM_FLAGS-1:0] pulse_n, fall, set_ev, clr_ev, flag_n;
  logic                 unused_addr;

  assign host_wr_act = !host_cs_ni && !host_wr_ni;
  assign host_rd_act = !host_cs_ni && !host_rd_ni && host_wr_ni;
  assign win         = host_addr_i[ADDR_W-1:WIN_LSB];
  assign in_down     = (win == WIN_DOWN);
  assign in_up       = (win == WIN_UP);
  assign unused_addr = ^host_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_wr_q <= 1'b0;
      host_rd_q <= 1'b0;
    end else begin
      host_wr_q <= host_wr_act;
      host_rd_q <= host_rd_act;
    end
  end

  // leading edge of an access is the event
  assign host_wr_ev = host_wr_act && !host_wr_q;
  assign host_rd_ev = host_rd_act && !host_rd_q;

  assign pulse_n[IDX_HW] = hw_ack_ni;
  assign pulse_n[IDX_HR] = hr_ack_ni;
  assign pulse_n[IDX_SW] = sw_req_ni;
  assign pulse_n[IDX_SR] = sr_req_ni;

  generate
    for (genvar g = 0; g < int'(NUM_FLAGS); g++) begin : g_line
      dpm_fall_det #(.STAGES(SYNC_STAGES)) u_det (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_ni(pulse_n[g]),
        .fall_o (fall[g])
      );
    end
  endgenerate

  // host side sets toward slave, slave acks clear
  assign set_ev[IDX_HW] = host_wr_ev && in_down;
  assign clr_ev[IDX_HW] = fall[IDX_HW];
  assign set_ev[IDX_HR] = host_rd_ev && in_up;
  assign clr_ev[IDX_HR] = fall[IDX_HR];
  // slave requests set toward host, host accesses clear
  assign set_ev[IDX_SW] = fall[IDX_SW];
  assign clr_ev[IDX_SW] = host_wr_ev && in_up;
  assign set_ev[IDX_SR] = fall[IDX_SR];
  assign clr_ev[IDX_SR] = host_rd_ev && in_down;

  generate
    for (genvar g = 0; g < int'(NUM_FLAGS); g++) begin : g_flag
      dpm_irq_flag u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_ev[g]),
        .clr_i  (clr_ev[g]),
        .flag_no(flag_n[g])
      );
    end
  endgenerate

  assign irq_hw_no = flag_n[IDX_HW];
  assign irq_hr_no = flag_n[IDX_HR];
  assign irq_sw_no = flag_n[IDX_SW];
  assign irq_sr_no = flag_n[IDX_SR];

  dpm_dual_ram #(.AW(MEM_AW), .DW(DATA_W)) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_en_i   (host_wr_act || host_rd_act),
    .a_we_i   (host_wr_act),
    .a_addr_i (host_addr_i[MEM_AW-1:0]),
    .a_wdata_i(host_wdata_i),
    .a_rdata_o(host_rdata_o),
    .b_en_i   (slv_en_i),
    .b_we_i   (slv_we_i),
    .b_addr_i (slv_addr_i),
    .b_wdata_i(slv_wdata_i),
    .b_rdata_o(slv_rdata_o),
    .clash_o  (collision_o)
  );

  // R2
  hw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_ev && in_down) |=> !irq_hw_no);
  // R5
  sw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_ev && in_up && !fall[IDX_SW]) |=> irq_sw_no);
  // R6
  sr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_ev && in_down && !fall[IDX_SR]) |=> irq_sr_no);
  // R9
  out_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((host_wr_act || host_rd_act) && !in_down && !in_up && fall == '0)
      |=> $stable(flag_n));
endmodule

// File: tb/sim_dpm_mailbox.sv
module sim_dpm_mailbox;
  localparam int ADDR_W = 16;
  localparam int MEM_AW = 10;
  localparam int DATA_W = 8;

  typedef struct {
    string       tag;
    logic [3:0]  fl;     // {sr, sw, hr, hw}
    logic        col;
    bit          ch_h;
    logic [7:0]  hv;
    bit          ch_s;
    logic [7:0]  sv;
  } item_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              host_cs_ni = 1'b1, host_wr_ni = 1'b1, host_rd_ni = 1'b1;
  logic [ADDR_W-1:0] host_addr_i = '0;
  logic [DATA_W-1:0] host_wdata_i = '0;
  logic [DATA_W-1:0] host_rdata_o;
  logic              slv_en_i = 1'b0, slv_we_i = 1'b0;
  logic [MEM_AW-1:0] slv_addr_i = '0;
  logic [DATA_W-1:0] slv_wdata_i = '0;
  logic [DATA_W-1:0] slv_rdata_o;
  logic              hw_ack_ni = 1'b1, hr_ack_ni = 1'b1, sw_req_ni = 1'b1, sr_req_ni = 1'b1;
  logic              irq_hw_no, irq_hr_no, irq_sw_no, irq_sr_no, collision_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  item_t sbq[$];

  logic m_hw = 1'b1, m_hr = 1'b1, m_sw = 1'b1, m_sr = 1'b1, m_col = 1'b0;

  always #10 clk_i = ~clk_i;

  dpm_mailbox u0 (
    .clk_i, .rst_ni, .host_cs_ni, .host_wr_ni, .host_rd_ni, .host_addr_i,
    .host_wdata_i, .host_rdata_o, .slv_en_i, .slv_we_i, .slv_addr_i,
    .slv_wdata_i, .slv_rdata_o, .hw_ack_ni, .hr_ack_ni, .sw_req_ni, .sr_req_ni,
    .irq_hw_no, .irq_hr_no, .irq_sw_no, .irq_sr_no, .collision_o
  );

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      while (sbq.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it  = sbq.pop_front();
        act = {irq_sr_no, irq_sw_no, irq_hr_no, irq_hw_no};
        n_chk++;
        if (act !== it.fl || collision_o !== it.col) begin
          n_bad++;
          $display("FAIL %s: flags/col act=%b/%b exp=%b/%b", it.tag, act, collision_o, it.fl, it.col);
        end else if (it.ch_h && host_rdata_o !== it.hv) begin
          n_bad++;
          $display("FAIL %s: host_rdata act=%h exp=%h", it.tag, host_rdata_o, it.hv);
        end else if (it.ch_s && slv_rdata_o !== it.sv) begin
          n_bad++;
          $display("FAIL %s: slv_rdata act=%h exp=%h", it.tag, slv_rdata_o, it.sv);
        end
      end
    end
  end

  // driver helpers: called right after a falling edge
  task automatic step(input string tag, input bit ch_h = 0, input logic [7:0] hv = 0,
                      input bit ch_s = 0, input logic [7:0] sv = 0);
    item_t it;
    it.tag = tag; it.fl = {m_sr, m_sw, m_hr, m_hw}; it.col = m_col;
    it.ch_h = ch_h; it.hv = hv; it.ch_s = ch_s; it.sv = sv;
    sbq.push_back(it);
    m_col = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic hwr(input logic [15:0] a, input logic [7:0] d);
    host_cs_ni = 0; host_wr_ni = 0; host_rd_ni = 1; host_addr_i = a; host_wdata_i = d;
  endtask
  task automatic hrd(input logic [15:0] a);
    host_cs_ni = 0; host_wr_ni = 1; host_rd_ni = 0; host_addr_i = a;
  endtask
  task automatic hidle();
    host_cs_ni = 1; host_wr_ni = 1; host_rd_ni = 1;
  endtask
  task automatic sacc(input logic we, input logic [9:0] a, input logic [7:0] d);
    slv_en_i = 1; slv_we_i = we; slv_addr_i = a; slv_wdata_i = d;
  endtask
  task automatic sidle();
    slv_en_i = 0; slv_we_i = 0;
  endtask

  task automatic set_line(input int sel, input logic v);
    case (sel)
      0: hw_ack_ni = v;
      1: hr_ack_ni = v;
      2: sw_req_ni = v;
      default: sr_req_ni = v;
    endcase
  endtask
  task automatic apply(input int sel);
    case (sel)
      0: m_hw = 1'b1;
      1: m_hr = 1'b1;
      2: m_sw = 1'b0;
      default: m_sr = 1'b0;
    endcase
  endtask
  // five-cycle low pulse; acts at the third edge
  task automatic pulse(input int sel, input string tag);
    set_line(sel, 1'b0);
    for (int i = 0; i < 5; i++) begin
      if (i == 2) apply(sel);
      step(tag);
    end
    set_line(sel, 1'b1);
    step(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    step("R1 in reset");
    step("R1 in reset");
    rst_ni = 1'b1;
    step("R1 after reset release");

    // R2 host write window 7, data also used for R11
    hwr(16'h7010, 8'hA5); m_hw = 0; step("R2 host write 0x7010");
    hidle(); step("R2 idle after write");
    // R11 slave reads what host wrote
    sacc(0, 10'h010, 8'h00); step("R11 slave read", 0, 0, 1, 8'hA5);
    sidle(); step("R11 idle");
    // R3 ack clears
    pulse(0, "R3 hw ack pulse");

    // R4 host read window B, then ack
    hrd(16'hB000); m_hr = 0; step("R4 host read 0xB000");
    hidle(); step("R4 idle");
    pulse(1, "R4 hr ack pulse");

    // R5 slave write request, host write window B clears
    pulse(2, "R5 sw req pulse");
    hwr(16'hB004, 8'h11); m_sw = 1; step("R5 host write 0xB004");
    hidle(); step("R5 idle");

    // R6 slave read request; slave stores a byte meanwhile
    sacc(1, 10'h020, 8'h3C);
    pulse(3, "R6 sr req pulse");
    sidle();
    hrd(16'h7020); m_sr = 1; step("R6 host read 0x7020 (R11 data)", 1, 8'h3C);
    hidle(); step("R6 idle");

    // R9 outside windows: raise sw and sr first
    pulse(2, "R9 prep sw");
    pulse(3, "R9 prep sr");
    hwr(16'h1234, 8'h77); step("R9 host write 0x1234");
    hrd(16'h3020); step("R9 host read 0x3020 aliased", 1, 8'h3C);
    hwr(16'hF000, 8'h55); step("R9 host write 0xF000");
    hrd(16'h0000); step("R9 host read 0x0000");
    hidle(); step("R9 idle");
    hwr(16'hB100, 8'h00); m_sw = 1; step("R5 clear sw");
    hrd(16'h7100); m_sr = 1; step("R6 clear sr");
    hidle(); step("R6 idle");

    // R7 held write strobe does not re-set after ack clears
    hwr(16'h7000, 8'h22); hw_ack_ni = 0; m_hw = 0; step("R7 held write start");
    step("R7 held write");
    m_hw = 1; step("R7 ack clears under held write");
    step("R7 held write no re-set");
    step("R7 held write no re-set");
    hidle(); hw_ack_ni = 1; step("R7 release");

    // R8 set wins: hw
    hw_ack_ni = 0; step("R8 ack sync");
    step("R8 ack sync");
    hwr(16'h7008, 8'h33); m_hw = 0; step("R8 hw set beats ack");
    hidle(); step("R7 ack still low, no clear");
    hw_ack_ni = 1; step("R8 release");
    // R8 set wins: sw
    sw_req_ni = 0; step("R8 req sync");
    step("R8 req sync");
    hwr(16'hB008, 8'h44); m_sw = 0; step("R8 sw set beats host write B");
    hidle(); sw_req_ni = 1; step("R8 release");
    hwr(16'hB00C, 8'h00); m_sw = 1; step("R5 clear sw");
    hidle(); step("R5 idle");
    pulse(0, "R3 clear hw");

    // R10 collisions
    hwr(16'h7040, 8'h66); sacc(0, 10'h040, 8'h00); m_hw = 0; m_col = 1; step("R10 hwrite/sread same cell");
    hidle(); sidle(); step("R10 one cycle only");
    hrd(16'h0040); sacc(0, 10'h040, 8'h00); step("R10 read/read no clash");
    hrd(16'h0050); sacc(1, 10'h050, 8'h99); m_col = 1; step("R10 hread/swrite same cell");
    hwr(16'h0060, 8'h01); sacc(1, 10'h061, 8'h02); step("R10 different cells");
    hwr(16'h1060, 8'h03); sacc(1, 10'h060, 8'h04); m_col = 1; step("R10 aliased write/write");
    hidle(); sidle(); step("R10 idle");

    // R1 reset mid-operation
    pulse(3, "R1 prep sr");
    rst_ni = 0; m_hw = 1; m_sr = 1; step("R1 reset mid-run");
    rst_ni = 1; step("R1 after second reset");

    @(posedge clk_i); #6;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule